// File: doc/BRIEF.md
# Vector Element Add Sequencer

This block performs a single vector addition over a register file in which each 64-bit register can be viewed as a packed array of 8-, 16-, 32- or 64-bit elements. Consecutive registers form one continuous byte space, so element `i` of a vector that starts at base register `b` lives at byte `8*b + i*bytes`. A start pulse supplies two source base registers, a destination base register, a source element width, a separate destination element width, a vector length and a saturation flag. The block then walks the element index upward, one element per clock.

Each step reads the source registers through two combinational read ports and extracts the element. It zero-extends both operands and adds them at the wider of the two widths, keeping the carry. It then narrows the sum to the destination width, either by keeping the low bits or by unsigned clamping. The result is written through one write port with byte enables, so that neighbouring elements in the same register are left untouched. A one-cycle done pulse follows the final write.

Top module: `vec_elem_add`

## Requirements
- R1: While reset is held and after its release with no start, busy, done and wr_en are all 0.
- R2: Width codes are 0 = 8, 1 = 16, 2 = 32 and 3 = 64 bits. Source element i of base b is read from register (b + (i*bytes)/8) mod NREGS, at byte lane (i*bytes) mod 8 of that register.
- R3: For destination element i, wr_reg is (base + (i*bytes)/8) mod NREGS. wr_be has exactly the element's bytes set, starting at lane (i*bytes) mod 8, and the result sits in wr_data at that lane.
- R4: With saturation off, the written element is the low destination-width bits of the zero-extended sum of the two source elements.
- R5: With saturation on, a sum (carry included) greater than the largest unsigned destination value writes that largest value. Any other sum is written unchanged.
- R6: A start accepted while idle with a nonzero length gives one write per cycle, beginning in the cycle after the start and covering indices 0 upward in order.
- R7: done is high for exactly one cycle, in the cycle after the last write. busy falls in that same cycle, and no write occurs while done is high.
- R8: A vector length of 0 raises done in the cycle after the start and performs no write.
- R9: A start that arrives while busy is ignored: the running operation keeps its parameters and its write count.
- R10: The vector length is 0 to 64. Values above 64 are treated as 64.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Begin an operation when idle |
| src1_base | input | log2(NREGS) | First source base register |
| src2_base | input | log2(NREGS) | Second source base register |
| dst_base | input | log2(NREGS) | Destination base register |
| src_wsel | input | 2 | Source element width code |
| dst_wsel | input | 2 | Destination element width code |
| vlen | input | 7 | Vector length |
| sat_en | input | 1 | Unsigned saturation on writeback |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle completion pulse |
| rd1_reg | output | log2(NREGS) | Read port 1 register index |
| rd1_data | input | 64 | Read port 1 data, combinational |
| rd2_reg | output | log2(NREGS) | Read port 2 register index |
| rd2_data | input | 64 | Read port 2 data, combinational |
| wr_en | output | 1 | Write strobe |
| wr_reg | output | log2(NREGS) | Write register index |
| wr_be | output | 8 | Byte enables of the write |
| wr_data | output | 64 | Write data, element placed at its lane |

## Verification
The bench builds the block with NREGS = 8 and the default maximum length of 64. With only eight registers, a 64-element vector of any width above 8 bits runs past the last register. That brings the modulo wrap of register indices within reach, and it also lets sources overlap the destination while earlier writes change later reads. All sixteen pairings of source and destination width are run with saturation both on and off, together with zero, maximum and over-range lengths and a start that arrives while busy.

// File: rtl/vec_elem_add.sv
module vec_elem_add #(
  parameter int NREGS = 32,
  parameter int MAXVL = 64,
  localparam int RAW = $clog2(NREGS),
  localparam int VLW = $clog2(MAXVL + 1),
  localparam int IW  = $clog2(MAXVL),
  localparam int OW  = IW + 3
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           start,
  input  logic [RAW-1:0] src1_base,
  input  logic [RAW-1:0] src2_base,
  input  logic [RAW-1:0] dst_base,
  input  logic [1:0]     src_wsel,
  input  logic [1:0]     dst_wsel,
  input  logic [VLW-1:0] vlen,
  input  logic           sat_en,
  output logic           busy,
  output logic           done,
  output logic [RAW-1:0] rd1_reg,
  input  logic [63:0]    rd1_data,
  output logic [RAW-1:0] rd2_reg,
  input  logic [63:0]    rd2_data,
  output logic           wr_en,
  output logic [RAW-1:0] wr_reg,
  output logic [7:0]     wr_be,
  output logic [63:0]    wr_data
);

  function automatic logic [63:0] elem_mask(input logic [1:0] w);
    case (w)
      2'd0:    return 64'h0000_0000_0000_00FF;
      2'd1:    return 64'h0000_0000_0000_FFFF;
      2'd2:    return 64'h0000_0000_FFFF_FFFF;
      default: return '1;
    endcase
  endfunction

  function automatic logic [7:0] byte_mask(input logic [1:0] w);
    case (w)
      2'd0:    return 8'h01;
      2'd1:    return 8'h03;
      2'd2:    return 8'h0F;
      default: return 8'hFF;
    endcase
  endfunction

  logic [RAW-1:0] s1_q, s2_q, d_q;
  logic [1:0]     sw_q, dw_q;
  logic           sat_q;
  logic [IW-1:0]  idx, last;
  logic [VLW-1:0] vl_eff;

  assign vl_eff = (vlen > VLW'(MAXVL)) ? VLW'(MAXVL) : vlen;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy  <= 1'b0;
      done  <= 1'b0;
      idx   <= '0;
      last  <= '0;
      s1_q  <= '0;
      s2_q  <= '0;
      d_q   <= '0;
      sw_q  <= '0;
      dw_q  <= '0;
      sat_q <= 1'b0;
    end else begin
      done <= 1'b0;
      if (!busy) begin
        if (start) begin
          s1_q  <= src1_base;
          s2_q  <= src2_base;
          d_q   <= dst_base;
          sw_q  <= src_wsel;
          dw_q  <= dst_wsel;
          sat_q <= sat_en;
          idx   <= '0;
          if (vl_eff == '0) begin
            done <= 1'b1;
          end else begin
            busy <= 1'b1;
            last <= IW'(vl_eff - 1'b1);
          end
        end
      end else if (idx == last) begin
        busy <= 1'b0;
        done <= 1'b1;
      end else begin
        idx <= idx + 1'b1;
      end
    end
  end

  logic [OW-1:0] soff, doff;
  logic [2:0]    slane, dlane;
  assign soff  = OW'(idx) << sw_q;
  assign doff  = OW'(idx) << dw_q;
  assign slane = soff[2:0];
  assign dlane = doff[2:0];

  assign rd1_reg = s1_q + RAW'(soff >> 3);
  assign rd2_reg = s2_q + RAW'(soff >> 3);
  assign wr_reg  = d_q  + RAW'(doff >> 3);

  logic [63:0] smask, dmax, opa, opb, res;
  logic [64:0] sum;
  logic        ovf;

  assign smask = elem_mask(sw_q);
  assign dmax  = elem_mask(dw_q);
  assign opa   = (rd1_data >> {slane, 3'b000}) & smask;
  assign opb   = (rd2_data >> {slane, 3'b000}) & smask;
  assign sum   = {1'b0, opa} + {1'b0, opb};
  assign ovf   = sum > {1'b0, dmax};
  assign res   = (sat_q && ovf) ? dmax : (sum[63:0] & dmax);

  assign wr_en   = busy;
  assign wr_be   = byte_mask(dw_q) << dlane;
  assign wr_data = res << {dlane, 3'b000};

endmodule

module vec_elem_add_chk #(
  parameter int RAW = 5,
  parameter int VLW = 7
) (
  input logic           clk,
  input logic           rst_n,
  input logic           start,
  input logic           busy,
  input logic           done,
  input logic [VLW-1:0] vlen,
  input logic           wr_en,
  input logic [7:0]     wr_be
);

  assert_done_pulse_R7: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  assert_done_quiet_R7: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (!wr_en && !busy));

  assert_empty_vector_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !busy && vlen == '0) |=> (done && !wr_en));

  assert_first_write_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !busy && vlen != '0) |=> (wr_en && !done));

  assert_byte_enables_R3: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |-> ($countones(wr_be) == 1 || $countones(wr_be) == 2 ||
               $countones(wr_be) == 4 || $countones(wr_be) == 8));

  assert_busy_start_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && start && !(wr_en && done)) |=> (busy || done));

endmodule

bind vec_elem_add vec_elem_add_chk #(.RAW(RAW), .VLW(VLW)) u_chk (
  .clk(clk), .rst_n(rst_n), .start(start), .busy(busy), .done(done),
  .vlen(vlen), .wr_en(wr_en), .wr_be(wr_be)
);

// File: tb/vec_elem_add_test.sv
`timescale 1ns/100ps
module vec_elem_add_test;
  localparam int NREGS = 8;
  localparam int RAW = $clog2(NREGS);
  localparam int NB = NREGS * 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start = 1'b0;
  logic [RAW-1:0] src1_base = '0, src2_base = '0, dst_base = '0;
  logic [1:0] src_wsel = '0, dst_wsel = '0;
  logic [6:0] vlen = '0;
  logic sat_en = 1'b0;
  logic busy, done, wr_en;
  logic [RAW-1:0] rd1_reg, rd2_reg, wr_reg;
  logic [63:0] rd1_data, rd2_data, wr_data;
  logic [7:0] wr_be;

  int checks = 0, errors = 0, cycles = 0, n_wr = 0;

  always #2.5 clk = ~clk;

  vec_elem_add #(.NREGS(NREGS), .MAXVL(64)) uut (
    .clk(clk), .rst_n(rst_n), .start(start),
    .src1_base(src1_base), .src2_base(src2_base), .dst_base(dst_base),
    .src_wsel(src_wsel), .dst_wsel(dst_wsel), .vlen(vlen), .sat_en(sat_en),
    .busy(busy), .done(done),
    .rd1_reg(rd1_reg), .rd1_data(rd1_data), .rd2_reg(rd2_reg), .rd2_data(rd2_data),
    .wr_en(wr_en), .wr_reg(wr_reg), .wr_be(wr_be), .wr_data(wr_data)
  );

  logic [7:0] mem [NB];

  always_comb begin
    for (int k = 0; k < 8; k++) begin
      rd1_data[k*8 +: 8] = mem[int'(rd1_reg) * 8 + k];
      rd2_data[k*8 +: 8] = mem[int'(rd2_reg) * 8 + k];
    end
  end

  // behavioural reference state
  bit m_busy = 0, m_done = 0, m_sat = 0;
  int m_s1 = 0, m_s2 = 0, m_d = 0, m_sw = 0, m_dw = 0, m_idx = 0, m_vl = 0;
  bit e_wr = 0;
  int e_reg = 0;
  logic [7:0] e_be = '0;
  logic [63:0] e_data = '0;

  always @(posedge clk) begin
    if (!rst_n) begin
      m_busy <= 0; m_done <= 0; m_idx <= 0;
    end else begin
      m_done <= 0;
      if (m_busy && e_wr)
        for (int k = 0; k < 8; k++)
          if (e_be[k]) mem[e_reg * 8 + k] <= e_data[k*8 +: 8];
      if (!m_busy) begin
        if (start) begin
          int v;
          v = (int'(vlen) > 64) ? 64 : int'(vlen);
          m_s1 <= int'(src1_base); m_s2 <= int'(src2_base); m_d <= int'(dst_base);
          m_sw <= int'(src_wsel); m_dw <= int'(dst_wsel); m_sat <= sat_en;
          m_idx <= 0; m_vl <= v;
          if (v == 0) m_done <= 1; else m_busy <= 1;
        end
      end else if (m_idx == m_vl - 1) begin
        m_busy <= 0; m_done <= 1;
      end else begin
        m_idx <= m_idx + 1;
      end
    end
  end

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %h expected %h at cycle %0d", req, act, exp, cycles);
    end
  endtask

  function automatic logic [63:0] get_elem(input int base, input int bytes, input int i);
    int a;
    logic [63:0] v;
    v = '0;
    a = (base * 8 + i * bytes) % NB;
    for (int k = 0; k < bytes; k++) v[k*8 +: 8] = mem[(a + k) % NB];
    return v;
  endfunction

  always @(negedge clk) begin
    cycles++;
    if (rst_n) begin
      e_wr = m_busy;
      check("R7 busy", 64'(busy), 64'(m_busy));
      check("R7 done", 64'(done), 64'(m_done));
      check("R6 wr_en", 64'(wr_en), 64'(m_busy));
      if (wr_en) n_wr++;
      if (m_busy) begin
        int sb, db, da, lane;
        logic [63:0] a, b, dmax, res;
        logic [64:0] s;
        sb = 1 << m_sw;
        db = 1 << m_dw;
        a = get_elem(m_s1, sb, m_idx);
        b = get_elem(m_s2, sb, m_idx);
        s = 65'(a) + 65'(b);
        dmax = (db == 8) ? '1 : ((64'd1 << (db * 8)) - 1);
        if (m_sat && s > 65'(dmax)) res = dmax;
        else res = s[63:0] & dmax;
        da = (m_d * 8 + m_idx * db) % NB;
        lane = da % 8;
        e_reg = da / 8;
        e_be = 8'(((1 << db) - 1) << lane);
        e_data = res << (lane * 8);
        check("R3 wr_reg", 64'(wr_reg), 64'(e_reg));
        check("R3 wr_be", 64'(wr_be), 64'(e_be));
        check(m_sat ? "R2 R5 wr_data" : "R2 R4 wr_data", wr_data & byte_bits(wr_be), e_data);
      end
    end
  end

  function automatic logic [63:0] byte_bits(input logic [7:0] be);
    logic [63:0] m;
    for (int k = 0; k < 8; k++) m[k*8 +: 8] = {8{be[k]}};
    return m;
  endfunction

  task automatic fill(input int seed);
    @(negedge clk);
    for (int k = 0; k < NB; k++) mem[k] = 8'((k * 37 + seed * 101 + (k * k) % 13) % 256);
  endtask

  task automatic launch(input int s1, input int s2, input int d, input int sw, input int dw,
                        input int vl, input bit sat);
    @(posedge clk); #1;
    src1_base = RAW'(s1); src2_base = RAW'(s2); dst_base = RAW'(d);
    src_wsel = 2'(sw); dst_wsel = 2'(dw); vlen = 7'(vl); sat_en = sat;
    start = 1'b1;
    n_wr = 0;
    @(posedge clk); #1;
    start = 1'b0;
  endtask

  task automatic run_op(input string req, input int s1, input int s2, input int d, input int sw,
                        input int dw, input int vl, input bit sat);
    int v;
    v = (vl > 64) ? 64 : vl;
    launch(s1, s2, d, sw, dw, vl, sat);
    repeat (v + 3) @(posedge clk);
    @(negedge clk);
    check(req, 64'(n_wr), 64'(v));
  endtask

  initial begin
    for (int k = 0; k < NB; k++) mem[k] = '0;
    repeat (3) @(negedge clk);
    check("R1 busy in reset", 64'(busy), 64'd0);
    check("R1 done in reset", 64'(done), 64'd0);
    check("R1 wr_en in reset", 64'(wr_en), 64'd0);
    @(posedge clk); #1 rst_n = 1'b1;
    repeat (2) @(negedge clk);
    check("R1 idle busy", 64'(busy), 64'd0);
    check("R1 idle wr_en", 64'(wr_en), 64'd0);

    fill(1);
    for (int sw = 0; sw < 4; sw++)
      for (int dw = 0; dw < 4; dw++) begin
        run_op("R6 count wrap", 1, 3, 5, sw, dw, 6, 1'b0);
        fill(sw * 4 + dw + 2);
        run_op("R6 count sat", 6, 2, 0, sw, dw, 7, 1'b1);
      end

    // saturation corner: all-ones operands
    @(negedge clk);
    for (int k = 0; k < NB; k++) mem[k] = 8'hFF;
    run_op("R5 count", 0, 1, 4, 0, 0, 8, 1'b1);
    check("R5 clamp byte", 64'(mem[32]), 64'hFF);
    run_op("R4 count", 0, 1, 4, 1, 0, 4, 1'b0);
    check("R4 wrap byte", 64'(mem[33]), 64'hFE);

    // full length and over-range, wrapping around the register file
    fill(40);
    run_op("R10 full length", 2, 7, 3, 3, 1, 64, 1'b0);
    fill(41);
    run_op("R10 over-range", 5, 5, 5, 2, 3, 100, 1'b1);
    run_op("R2 overlap", 0, 1, 0, 0, 0, 64, 1'b0);

    // empty vector
    launch(1, 2, 3, 0, 0, 0, 1'b0);
    @(negedge clk);
    check("R8 no write", 64'(wr_en), 64'd0);
    repeat (3) @(negedge clk);
    check("R8 write count", 64'(n_wr), 64'd0);

    // start while busy is ignored
    fill(50);
    launch(0, 1, 2, 2, 2, 10, 1'b0);
    repeat (3) @(posedge clk);
    #1;
    src1_base = RAW'(4); dst_base = RAW'(6); vlen = 7'd2; dst_wsel = 2'd0; start = 1'b1;
    @(posedge clk); #1 start = 1'b0;
    repeat (12) @(posedge clk);
    @(negedge clk);
    check("R9 write count", 64'(n_wr), 64'd10);

    // back-to-back single elements
    run_op("R6 single", 3, 4, 7, 3, 3, 1, 1'b1);
    run_op("R7 single", 7, 0, 1, 0, 3, 1, 1'b0);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual timeout expected completion");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule